// File: doc/BRIEF.md
# Partial-Word Merger for Unaligned Word Access

This block carries out the four partial-word transfer instructions of a classic 32-bit load/store processor: the left and right halves of an unaligned word load, and the left and right halves of an unaligned word store. It works on a little-endian memory that is organised in whole words. A request brings an opcode, a byte address and the current value of the register involved. The block always reads the aligned word that contains the byte address. The low address bits then pick which byte lanes come from memory and which come from the register.

For a load, the merged word is the new register value. It is returned with a one-cycle completion strobe. For a store, the merged word goes back to the same aligned address in one write, and the register is not changed. The block talks to a plain synchronous memory port whose read data arrives one cycle after the read strobe. The data width is a parameter and must be a power-of-two number of bytes.

Top module: `pw_merge_top`

## Requirements
- R1: Every memory read and write uses the request address with its low byte-offset bits (bits 1:0 at the default width) cleared. A store writes back to exactly the word it read.
- R2: Opcode 00, load-left at byte offset k: result = (memory word << (24 - 8k)) | (register & (0xFFFFFFFF >> (8k + 8))). At k = 3 the result is the whole memory word.
- R3: Opcode 01, load-right at offset k: result = (memory word >> 8k) | (register & ~(0xFFFFFFFF >> 8k)). At k = 0 the result is the whole memory word.
- R4: Opcode 10, store-left at offset k: the word written = (register >> (24 - 8k)) | (memory word & ~(0xFFFFFFFF >> (24 - 8k))). At k = 3 the whole register is written.
- R5: Opcode 11, store-right at offset k: the word written = (register << 8k) | (memory word & ~(0xFFFFFFFF << 8k)). At k = 0 the whole register is written.
- R6: A load whose destination register index is zero returns the supplied register value unchanged, whatever the memory word holds.
- R7: Take the accepting cycle as cycle 0. The read strobe is high in cycle 1. A load signals completion in cycle 3 and never writes memory. A store writes exactly once, in cycle 3, and signals completion in cycle 4.
- R8: Completion is high for exactly one cycle. The result-valid flag is high only together with completion, and only for loads.
- R9: The request-ready output is high only while the block is idle. A request presented while ready is low has no effect on any operation.
- R10: While reset is held, ready is high and completion, result-valid, read strobe and write strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; the request is taken on this cycle |
| req_op | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| req_addr | input | AW (32) | Byte address |
| req_idx | input | RIW (5) | Destination/source register index |
| req_reg | input | DW (32) | Current register value |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW (32) | Word-aligned memory address |
| mem_wdata | output | DW (32) | Merged store word |
| mem_rdata | input | DW (32) | Read data, one cycle after mem_rd |
| done | output | 1 | One-cycle completion pulse |
| result_valid | output | 1 | Result carries a load value |
| result | output | DW (32) | Merged register value |

## Verification
Suppose the sequencer enters the wrong state. The ports show it within one or two cycles: the completion pulse lands on the wrong cycle, a load raises the write strobe, or a store writes more than once or not at all. A wrong lane choice in the merge shows up on the very next completion. It appears as a wrong byte in the returned result, or as a wrong byte in the bench's memory word after the store's write. Running every offset under each opcode, with distinct byte values in every lane, pins each lane's source.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   typedef enum logic [1:0] {
      OP_LOAD_LEFT   = 2'b00,
      OP_LOAD_RIGHT  = 2'b01,
      OP_STORE_LEFT  = 2'b10,
      OP_STORE_RIGHT = 2'b11
   } pwm_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_MERGE,
      ST_WRITE,
      ST_DONE
   } pwm_state_e;

   function automatic logic op_is_store(pwm_op_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/pwm_lane_merge.sv
module pwm_lane_merge
   import pwm_pkg::*;
#(
   parameter int DW = 32,
   localparam int NB = DW / 8,
   localparam int OB = $clog2(NB)
)(
   input  pwm_op_e          op,
   input  logic [OB-1:0]    ofs,
   input  logic [DW-1:0]    mem_word,
   input  logic [DW-1:0]    reg_word,
   output logic [DW-1:0]    merged
);

   function automatic logic [7:0] byte_at(logic [DW-1:0] w, int idx);
      logic [DW-1:0] t;
      t = w >> (8 * idx);
      return t[7:0];
   endfunction

   for (genvar j = 0; j < NB; j++) begin : g_lane
      logic [7:0] lane_b;

      always_comb begin
         int k;
         int src;
         k   = int'(ofs);
         src = 0;
         if (op_is_store(op)) lane_b = byte_at(mem_word, j);
         else                 lane_b = byte_at(reg_word, j);
         unique case (op)
            OP_LOAD_LEFT: begin
               src = j - (NB - 1 - k);
               if (src >= 0) lane_b = byte_at(mem_word, src);
            end
            OP_LOAD_RIGHT: begin
               src = j + k;
               if (src <= NB - 1) lane_b = byte_at(mem_word, src);
            end
            OP_STORE_LEFT: begin
               src = j + (NB - 1 - k);
               if (j <= k) lane_b = byte_at(reg_word, src);
            end
            OP_STORE_RIGHT: begin
               src = j - k;
               if (j >= k) lane_b = byte_at(reg_word, src);
            end
            default: ;
         endcase
      end

      assign merged[8*j +: 8] = lane_b;
   end

endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
   import pwm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_fire,
   input  logic is_store,
   output logic ready,
   output logic rd,
   output logic wr,
   output logic merge_en,
   output logic done
);

   pwm_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_fire) state_d = ST_READ;
         ST_READ:  state_d = ST_MERGE;
         ST_MERGE: state_d = is_store ? ST_WRITE : ST_DONE;
         ST_WRITE: state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign ready    = (state_q == ST_IDLE);
   assign rd       = (state_q == ST_READ);
   assign merge_en = (state_q == ST_MERGE);
   assign wr       = (state_q == ST_WRITE);
   assign done     = (state_q == ST_DONE);

   // R7
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && wr));

   // R1
   write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> $past(rd, 2));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   accept_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_fire) |=> rd);

endmodule

// File: rtl/pw_merge_top.sv
module pw_merge_top
   import pwm_pkg::*;
#(
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int RIW = 5,
   localparam int NB = DW / 8,
   localparam int OB = $clog2(NB)
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [1:0]     req_op,
   input  logic [AW-1:0]  req_addr,
   input  logic [RIW-1:0] req_idx,
   input  logic [DW-1:0]  req_reg,
   output logic           mem_rd,
   output logic           mem_wr,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata,
   output logic           done,
   output logic           result_valid,
   output logic [DW-1:0]  result
);

   if ((DW % 8) != 0 || NB < 2 || (NB & (NB - 1)) != 0 || AW <= OB || RIW < 1)
   begin : g_bad_cfg
      $error("pw_merge_top: DW must be a power-of-two byte count >= 2, AW > offset bits");
   end

   pwm_op_e          op_q;
   logic [AW-1:0]    addr_q;
   logic [DW-1:0]    reg_q;
   logic             idx_zero_q;
   logic [DW-1:0]    merge_q;
   logic [DW-1:0]    merged;
   logic             merge_en;
   logic             req_fire;
   logic             is_store;

   assign req_fire = req_valid && req_ready;
   assign is_store = op_is_store(op_q);

   pwm_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_fire (req_fire),
      .is_store (is_store),
      .ready    (req_ready),
      .rd       (mem_rd),
      .wr       (mem_wr),
      .merge_en (merge_en),
      .done     (done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q       <= OP_LOAD_LEFT;
         addr_q     <= '0;
         reg_q      <= '0;
         idx_zero_q <= 1'b0;
      end else if (req_fire) begin
         op_q       <= pwm_op_e'(req_op);
         addr_q     <= req_addr;
         reg_q      <= req_reg;
         idx_zero_q <= (req_idx == '0);
      end
   end

   pwm_lane_merge #(.DW(DW)) u_merge (
      .op       (op_q),
      .ofs      (addr_q[OB-1:0]),
      .mem_word (mem_rdata),
      .reg_word (reg_q),
      .merged   (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        merge_q <= '0;
      else if (merge_en) merge_q <= (!is_store && idx_zero_q) ? reg_q : merged;
   end

   assign mem_addr     = {addr_q[AW-1:OB], {OB{1'b0}}};
   assign mem_wdata    = merge_q;
   assign result       = merge_q;
   assign result_valid = done && !is_store;

   // R1
   aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (mem_addr[OB-1:0] == '0));

   // R1
   same_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_addr == $past(mem_addr, 2)));

   // R7
   load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> is_store);

   // R8
   result_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> done);

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> $stable(op_q) && $stable(addr_q) && $stable(reg_q));

endmodule

// File: tb/sim_pw_merge_top.sv
`timescale 1ns/1ps
module sim_pw_merge_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'b00;
   logic [31:0] req_addr = '0;
   logic [4:0]  req_idx = '0;
   logic [31:0] req_reg = '0;
   logic        mem_rd, mem_wr;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        done, result_valid;
   logic [31:0] result;

   always #4 clk = ~clk;

   pw_merge_top u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_idx(req_idx), .req_reg(req_reg),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .done(done), .result_valid(result_valid), .result(result)
   );

   logic [31:0] mem    [16];
   logic [31:0] shadow [16];
   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int wr_seen = 0;
   bit prev_done = 0;
   bit finished = 0;

   typedef struct {
      logic [1:0]  op;
      logic [31:0] exp;
      int          idx;
      int          acc;
      bit          poke;
      bit          zero_dst;
   } item_t;
   item_t exp_q[$];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_rd) mem_rdata <= mem[mem_addr[5:2]];
      if (mem_wr) mem[mem_addr[5:2]] <= mem_wdata;
   end

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model(logic [1:0] op, int k, logic [31:0] m, logic [31:0] r);
      logic [31:0] ones = 32'hFFFF_FFFF;
      case (op)
         2'b00:   return (m << (24 - 8*k)) | (r & (ones >> (8*k + 8)));
         2'b01:   return (m >> (8*k)) | (r & ~(ones >> (8*k)));
         2'b10:   return (r >> (24 - 8*k)) | (m & ~(ones >> (24 - 8*k)));
         default: return (r << (8*k)) | (m & ~(ones << (8*k)));
      endcase
   endfunction

   function automatic string op_tag(logic [1:0] op);
      case (op)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic do_op(logic [1:0] op, logic [31:0] addr, logic [4:0] idx,
                        logic [31:0] regv, bit poke);
      item_t it;
      int k;
      k = int'(addr[1:0]);
      it.op = op;
      it.idx = int'(addr[5:2]);
      it.poke = poke;
      it.zero_dst = (!op[1] && idx == 5'd0);
      it.exp = model(op, k, shadow[it.idx], regv);
      if (it.zero_dst) it.exp = regv;
      if (op[1]) shadow[it.idx] = it.exp;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = addr; req_idx = idx; req_reg = regv;
      it.acc = cyc;
      exp_q.push_back(it);
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         // R9: offer a conflicting request while busy
         req_valid = 1'b1; req_op = ~op; req_addr = addr ^ 32'h7; req_idx = 5'd9;
         req_reg = ~regv;
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd || mem_wr)
            chk(mem_addr[1:0] == 2'b00, "R1 aligned address", mem_addr, {mem_addr[31:2], 2'b00});
         if (mem_wr) wr_seen++;
         if (done && prev_done) chk(1'b0, "R8 done pulse width", 32'd1, 32'd0);
         if (done) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected completion", 32'd1, 32'd0);
            end else begin
               item_t it;
               int lat;
               string t;
               it = exp_q.pop_front();
               lat = it.op[1] ? 4 : 3;
               t = it.poke ? "R9" : (it.zero_dst ? "R6" : op_tag(it.op));
               chk(cyc - it.acc == lat, "R7 completion latency", 32'(cyc - it.acc), 32'(lat));
               chk(wr_seen == (it.op[1] ? 1 : 0), "R7 write count", 32'(wr_seen),
                   32'(it.op[1] ? 1 : 0));
               chk(result_valid == !it.op[1], "R8 result_valid", 32'(result_valid),
                   32'(!it.op[1]));
               if (it.op[1]) chk(mem[it.idx] == it.exp, {t, " stored word"}, mem[it.idx], it.exp);
               else          chk(result == it.exp, {t, " load result"}, result, it.exp);
            end
            wr_seen = 0;
         end
         prev_done = done;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem[i]    = 32'h1020_3040 + i * 32'h0101_0101;
         shadow[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(req_ready == 1'b1, "R10 ready in reset", 32'(req_ready), 32'd1);
      chk(!done && !result_valid, "R10 done low in reset", 32'(done), 32'd0);
      chk(!mem_rd && !mem_wr, "R10 strobes low in reset", {mem_rd, mem_wr}, 32'd0);
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) do_op(2'b00, 32'h0000_0004 + 32'(k), 5'd3, 32'hA1B2_C3D4, 1'b0);
      for (int k = 0; k < 4; k++) do_op(2'b01, 32'h0000_0008 + 32'(k), 5'd4, 32'hE5F6_0718, 1'b0);
      for (int k = 0; k < 4; k++) do_op(2'b10, 32'h0000_0010 + 32'(k), 5'd5, 32'h99AA_BBCC, 1'b0);
      for (int k = 0; k < 4; k++) do_op(2'b11, 32'h0000_0020 + 32'(k), 5'd6, 32'h5566_7788, 1'b0);
      // stores then loads on the same word: read back through the load path
      do_op(2'b10, 32'h0000_0031, 5'd7, 32'hDEAD_BEEF, 1'b0);
      do_op(2'b11, 32'h0000_0032, 5'd7, 32'hCAFE_F00D, 1'b0);
      do_op(2'b01, 32'h0000_0030, 5'd8, 32'h0, 1'b0);
      // R6: destination index zero
      do_op(2'b00, 32'h0000_0015, 5'd0, 32'h1357_9BDF, 1'b0);
      do_op(2'b01, 32'h0000_0026, 5'd0, 32'h2468_ACE0, 1'b0);
      // R9: requests while busy are ignored
      do_op(2'b00, 32'h0000_0039, 5'd2, 32'h0F0F_0F0F, 1'b1);
      do_op(2'b11, 32'h0000_003D, 5'd2, 32'hF0E1_D2C3, 1'b1);
      do_op(2'b01, 32'h0000_003C, 5'd2, 32'h0, 1'b0);
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(req_ready == 1'b1, "R9 idle ready after run", 32'(req_ready), 32'd1);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule